// File: doc/BRIEF.md
# Single-Shot Conversion Sequencer

This block sits between a small register bus and an external multiplexed analog-to-digital converter. Software writes a control word holding a go bit, a channel number and an optional settle request. The sequencer then sets the converter's input multiplexer, waits a fixed settling time if one was asked for, and issues a one-cycle convert strobe. When the converter answers with its done handshake, the sequencer captures the sample into a data register and raises an end-of-conversion flag in an interrupt status register.

The settling delay is meant for the first sample after a channel change: software sets the request bit on that one write and leaves it clear on later writes to the same channel. The delay length is computed at elaboration from the clock frequency and the wanted settle time. The flag is cleared by writing a one to it. An interrupt line is raised while the flag and its enable bit are both set. Ten channels are valid: eight external inputs, a full-scale reference (channel 8) and a zero reference (channel 9).

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, conv_start and irq are 0, the busy bit (bit 0 at address 0x02) is 0, the data register (0x08) reads 0 and the status register (0x0A) reads 0.
- R2: A write to the control word (0x00) with bit 0 set, bit 15 clear and channel field bits [4:1] below 10 drives mux_sel to that channel and raises conv_start for exactly one cycle, in the cycle right after the write edge.
- R3: When bit 15 is also set, conv_start comes SETTLE_CYC cycles later than in R2 (SETTLE_CYC = CLK_KHZ * SETTLE_NS / 1,000,000); the delay applies only to that one conversion.
- R4: A go write whose channel field is 10 or higher is ignored: no strobe, busy stays 0 and mux_sel keeps its value.
- R5: A go write while a conversion is in progress is ignored: mux_sel keeps the running channel and no extra strobe is produced.
- R6: The busy bit is 1 from the cycle after an accepted go write until the cycle after the done handshake.
- R7: The data register takes conv_data only on the edge where conv_done is high during a conversion, and holds it until the next completion.
- R8: Completion sets bit 2 of the status register; writing a word with bit 2 set clears it, a write with bit 2 clear leaves it unchanged.
- R9: irq equals status bit 2 AND bit 2 of the interrupt enable register (0x0C, read/write).
- R10: conv_done while no conversion is running changes neither the data register nor the status flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | ADDR_W | Register write address (byte offset) |
| wr_data | input | 16 | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| mux_sel | output | CH_W | Converter input multiplexer select |
| conv_start | output | 1 | One-cycle convert strobe |
| conv_done | input | 1 | Converter done handshake, one cycle |
| conv_data | input | DATA_W | Converter sample, valid with conv_done |
| irq | output | 1 | Interrupt request |

## Verification
The strobe is due in the cycle after the write edge, or SETTLE_CYC cycles after that when settling is requested; a monitor stamps each write edge with a cycle count and checks the strobe against the front of the expected queue at the falling edge where it must first be seen, so an early, late or surplus strobe fails. The converter stub answers a fixed number of cycles after the strobe; the data register and flag are due one edge after done, so the bench reads them only after busy has dropped. Ignored writes and idle done pulses are followed by reads of busy, data and status, plus the monitor's watch for stray strobes.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETTLE = 2'd1,
      ST_FIRE   = 2'd2,
      ST_WAIT   = 2'd3
   } seq_state_e;

   localparam int unsigned REG_W     = 16;
   // register byte offsets
   localparam int unsigned OFS_CTRL  = 'h00;
   localparam int unsigned OFS_BUSY  = 'h02;
   localparam int unsigned OFS_DATA  = 'h08;
   localparam int unsigned OFS_ISTAT = 'h0A;
   localparam int unsigned OFS_IEN   = 'h0C;
   // field positions
   localparam int unsigned BIT_GO     = 0;
   localparam int unsigned CH_LSB     = 1;
   localparam int unsigned BIT_SETTLE = 15;
   localparam int unsigned BIT_EOC    = 2;

endpackage

// File: rtl/adc_seq_regif.sv
module adc_seq_regif
   import adc_seq_pkg::*;
#(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned CH_W   = 4,
   parameter int unsigned NUM_CH = 10,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [REG_W-1:0]  rd_data,
   input  logic              busy,
   input  logic [DATA_W-1:0] result,
   input  logic              eoc_set,
   input  logic [CH_W-1:0]   cur_ch,
   output logic              go_req,
   output logic [CH_W-1:0]   go_ch,
   output logic              go_settle,
   output logic              eoc_flag,
   output logic              irq
);

   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_BUSY  = ADDR_W'(OFS_BUSY);
   localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(OFS_DATA);
   localparam logic [ADDR_W-1:0] A_ISTAT = ADDR_W'(OFS_ISTAT);
   localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(OFS_IEN);

   logic wr_ctrl, wr_istat, wr_ien;
   logic ch_ok;
   logic eoc_en_q;
   logic eoc_q;

   assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
   assign wr_istat = wr_en && (wr_addr == A_ISTAT);
   assign wr_ien   = wr_en && (wr_addr == A_IEN);

   assign go_ch     = wr_data[CH_LSB +: CH_W];
   assign go_settle = wr_data[BIT_SETTLE];
   assign ch_ok     = ({1'b0, go_ch} < (CH_W+1)'(NUM_CH));
   assign go_req    = wr_ctrl && wr_data[BIT_GO] && ch_ok && !busy;

   // enable register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      eoc_en_q <= 1'b0;
      else if (wr_ien) eoc_en_q <= wr_data[BIT_EOC];
   end

   // write-one-to-clear flag, a completion in the same cycle wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              eoc_q <= 1'b0;
      else if (eoc_set)                        eoc_q <= 1'b1;
      else if (wr_istat && wr_data[BIT_EOC])   eoc_q <= 1'b0;
   end

   assign eoc_flag = eoc_q;
   assign irq      = eoc_q && eoc_en_q;

   always_comb begin
      rd_data = '0;
      unique case (rd_addr)
         A_CTRL:  rd_data[CH_LSB +: CH_W] = cur_ch;
         A_BUSY:  rd_data[0] = busy;
         A_DATA:  rd_data[DATA_W-1:0] = result;
         A_ISTAT: rd_data[BIT_EOC] = eoc_q;
         A_IEN:   rd_data[BIT_EOC] = eoc_en_q;
         default: rd_data = '0;
      endcase
   end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
   import adc_seq_pkg::*;
#(
   parameter int unsigned CH_W       = 4,
   parameter int unsigned SETTLE_CYC = 750
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go_req,
   input  logic [CH_W-1:0] go_ch,
   input  logic            go_settle,
   input  logic            conv_done,
   output logic [CH_W-1:0] mux_sel,
   output logic            conv_start,
   output logic            busy,
   output logic            capture
);

   seq_state_e state_q;
   logic [CH_W-1:0] ch_q;
   logic settle_end;
   logic use_settle;

   generate
      if (SETTLE_CYC == 0) begin : g_no_settle
         assign use_settle = 1'b0;
         assign settle_end = 1'b1;
      end else begin : g_settle
         localparam int unsigned CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
         localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  cnt_q <= '0;
            else if (state_q != ST_SETTLE) cnt_q <= '0;
            else                         cnt_q <= cnt_q + 1'b1;
         end
         assign use_settle = go_settle;
         assign settle_end = (cnt_q == CNT_LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ch_q    <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (go_req) begin
               ch_q    <= go_ch;
               state_q <= use_settle ? ST_SETTLE : ST_FIRE;
            end
            ST_SETTLE: if (settle_end) state_q <= ST_FIRE;
            ST_FIRE:   state_q <= ST_WAIT;
            ST_WAIT:   if (conv_done) state_q <= ST_IDLE;
            default:   state_q <= ST_IDLE;
         endcase
      end
   end

   assign mux_sel    = ch_q;
   assign conv_start = (state_q == ST_FIRE);
   assign busy       = (state_q != ST_IDLE);
   assign capture    = (state_q == ST_WAIT) && conv_done;

endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [DATA_W-1:0] conv_data,
   output logic [DATA_W-1:0] result
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       result <= '0;
      else if (capture) result <= conv_data;
   end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned CH_W      = 4,
   parameter int unsigned NUM_CH    = 10,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned CLK_KHZ   = 50000,
   parameter int unsigned SETTLE_NS = 15000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [15:0]       wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [15:0]       rd_data,
   output logic [CH_W-1:0]   mux_sel,
   output logic              conv_start,
   input  logic              conv_done,
   input  logic [DATA_W-1:0] conv_data,
   output logic              irq
);

   localparam longint unsigned SETTLE_L = (longint'(CLK_KHZ) * longint'(SETTLE_NS)) / 64'd1000000;
   localparam int unsigned SETTLE_CYC = int'(SETTLE_L);

   generate
      if (DATA_W > REG_W) begin : g_bad_data_w
         $error("DATA_W must not exceed the register width");
      end
      if (CH_LSB + CH_W > BIT_SETTLE) begin : g_bad_ch_w
         $error("channel field overlaps the settle bit");
      end
      if (NUM_CH > (1 << CH_W) || NUM_CH == 0) begin : g_bad_num_ch
         $error("NUM_CH does not fit CH_W");
      end
      if (ADDR_W < 4) begin : g_bad_addr_w
         $error("ADDR_W too small for the register offsets");
      end
   endgenerate

   logic              go_req, go_settle;
   logic [CH_W-1:0]   go_ch;
   logic              busy_w, capture_w, eoc_w;
   logic [DATA_W-1:0] result_w;

   adc_seq_regif #(
      .ADDR_W(ADDR_W), .CH_W(CH_W), .NUM_CH(NUM_CH), .DATA_W(DATA_W)
   ) u_regif (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .busy(busy_w), .result(result_w), .eoc_set(capture_w), .cur_ch(mux_sel),
      .go_req(go_req), .go_ch(go_ch), .go_settle(go_settle),
      .eoc_flag(eoc_w), .irq(irq)
   );

   adc_seq_fsm #(
      .CH_W(CH_W), .SETTLE_CYC(SETTLE_CYC)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .go_req(go_req), .go_ch(go_ch), .go_settle(go_settle),
      .conv_done(conv_done),
      .mux_sel(mux_sel), .conv_start(conv_start),
      .busy(busy_w), .capture(capture_w)
   );

   adc_seq_result #(
      .DATA_W(DATA_W)
   ) u_result (
      .clk(clk), .rst_n(rst_n),
      .capture(capture_w), .conv_data(conv_data),
      .result(result_w)
   );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
   parameter int unsigned CH_W   = 4,
   parameter int unsigned DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              conv_start,
   input logic              conv_done,
   input logic [CH_W-1:0]   mux_sel,
   input logic              busy,
   input logic [DATA_W-1:0] result,
   input logic              eoc,
   input logic              irq
);

   // R2: the strobe lasts a single cycle
   a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   // R6: a strobe only happens inside a busy window
   a_r6_busy_at_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> busy);

   // R5: the channel stays put for the whole conversion
   a_r5_mux_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(mux_sel));

   // R7 / R10: the result moves only after a done seen while busy
   a_r7_result_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> $past(conv_done && busy));

   // R8: the flag rises only because of a completion
   a_r8_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eoc) |-> $past(conv_done && busy));

   // R9: no interrupt without the flag
   a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> eoc);

endmodule

bind adc_seq_ctrl adc_seq_chk #(.CH_W(CH_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_done(conv_done),
   .mux_sel(mux_sel), .busy(busy_w), .result(result_w), .eoc(eoc_w), .irq(irq)
);

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;

   localparam int unsigned ADDR_W   = 5;
   localparam int unsigned CH_W     = 4;
   localparam int unsigned DATA_W   = 16;
   localparam int unsigned CLK_KHZ  = 200000;
   localparam int unsigned SET_NS   = 15000;
   localparam int          SC       = 3000;   // 200 MHz * 15 us
   localparam int          DONE_DLY = 6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [15:0]       wr_data = '0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [15:0]       rd_data;
   logic [CH_W-1:0]   mux_sel;
   logic              conv_start;
   logic              conv_done;
   logic [DATA_W-1:0] conv_data;
   logic              irq;

   logic              stub_done = 1'b0;
   logic [DATA_W-1:0] stub_data = '0;
   logic              inj_done = 1'b0;
   logic [DATA_W-1:0] inj_data = '0;
   int                pend = 0;
   logic [CH_W-1:0]   pend_ch = '0;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int exp_ch_q[$];
   int exp_cyc_q[$];

   assign conv_done = stub_done | inj_done;
   assign conv_data = inj_done ? inj_data : stub_data;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   adc_seq_ctrl #(
      .ADDR_W(ADDR_W), .CH_W(CH_W), .NUM_CH(10), .DATA_W(DATA_W),
      .CLK_KHZ(CLK_KHZ), .SETTLE_NS(SET_NS)
   ) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .mux_sel(mux_sel),
      .conv_start(conv_start), .conv_done(conv_done), .conv_data(conv_data), .irq(irq)
   );

   function automatic logic [DATA_W-1:0] sample_of(input logic [CH_W-1:0] ch);
      return 16'h5A00 ^ (16'h0111 * {12'd0, ch});
   endfunction

   // converter stub: done DONE_DLY cycles after the strobe
   always @(posedge clk) begin
      if (conv_start) begin
         pend      <= DONE_DLY;
         pend_ch   <= mux_sel;
         stub_done <= 1'b0;
      end else if (pend > 0) begin
         pend      <= pend - 1;
         stub_done <= (pend == 1);
         stub_data <= sample_of(pend_ch);
      end else begin
         stub_done <= 1'b0;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: each strobe must match the front of the expected queue
   always @(negedge clk) begin
      if (rst_n && conv_start) begin
         if (exp_ch_q.size() == 0) begin
            total++; bad++;
            $display("FAIL R4/R5 stray strobe actual=ch%0d expected=none", mux_sel);
         end else begin
            int ech, ecy;
            ech = exp_ch_q.pop_front();
            ecy = exp_cyc_q.pop_front();
            check("R2 mux_sel at strobe", 32'(mux_sel), 32'(ech));
            check("R2/R3 strobe cycle", 32'(cyc), 32'(ecy));
         end
      end
   end

   task automatic reg_wr(input int addr, input logic [15:0] d, output int edge_cyc);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = ADDR_W'(addr); wr_data = d;
      @(posedge clk);
      #1 edge_cyc = cyc;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic reg_rd(input int addr, output logic [15:0] d);
      @(negedge clk);
      rd_addr = ADDR_W'(addr);
      #1 d = rd_data;
   endtask

   // driver: push expectation, then issue the go write
   task automatic start_conv(input int ch, input bit settle);
      int e;
      logic [15:0] w;
      w = 16'(1) | 16'(ch << 1) | (settle ? 16'h8000 : 16'h0);
      exp_ch_q.push_back(ch);
      // edge cycle is stamped after the write; compute delay relative to cyc at issue
      @(negedge clk);
      exp_cyc_q.push_back(cyc + 1 + (settle ? SC : 0));
      wr_en = 1'b1; wr_addr = '0; wr_data = w;
      @(posedge clk);
      #1 e = cyc;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_idle();
      logic [15:0] d;
      int n = 0;
      do begin
         reg_rd('h02, d);
         n++;
      end while (d[0] && n < 10000);
   endtask

   task automatic clear_flag();
      int e;
      reg_wr('h0A, 16'h0004, e);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [15:0] d;
      int e;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      check("R1 conv_start", 32'(conv_start), 0);
      check("R1 irq", 32'(irq), 0);
      reg_rd('h02, d); check("R1 busy", 32'(d), 0);
      reg_rd('h08, d); check("R1 data", 32'(d), 0);
      reg_rd('h0A, d); check("R1 status", 32'(d), 0);

      // R2 plain conversion, R6 busy, R7 data, R8 flag
      start_conv(3, 1'b0);
      reg_rd('h02, d); check("R6 busy during conversion", 32'(d[0]), 1);
      wait_idle();
      reg_rd('h08, d); check("R7 data ch3", 32'(d), 32'(sample_of(4'd3)));
      reg_rd('h0A, d); check("R8 flag set", 32'(d), 32'h4);
      check("R9 irq masked", 32'(irq), 0);

      // R9 enable then R8 clear
      reg_wr('h0C, 16'h0004, e);
      reg_rd('h0C, d); check("R9 enable readback", 32'(d), 32'h4);
      @(negedge clk); check("R9 irq on", 32'(irq), 1);
      reg_wr('h0A, 16'h0000, e);
      reg_rd('h0A, d); check("R8 write zero keeps flag", 32'(d), 32'h4);
      clear_flag();
      reg_rd('h0A, d); check("R8 write one clears", 32'(d), 0);
      @(negedge clk); check("R9 irq off", 32'(irq), 0);

      // R3 settle on channel change, then none on repeat
      start_conv(8, 1'b1);
      wait_idle();
      reg_rd('h08, d); check("R3 data ch8", 32'(d), 32'(sample_of(4'd8)));
      start_conv(8, 1'b0);
      wait_idle();
      reg_rd('h08, d); check("R3 data repeat ch8", 32'(d), 32'(sample_of(4'd8)));
      start_conv(9, 1'b0);
      wait_idle();
      reg_rd('h08, d); check("R2 data ch9", 32'(d), 32'(sample_of(4'd9)));
      clear_flag();

      // R4 invalid channel ignored
      reg_wr('h00, 16'h0001 | 16'(12 << 1), e);
      repeat (10) @(negedge clk);
      reg_rd('h02, d); check("R4 busy stays low", 32'(d), 0);
      check("R4 mux_sel kept", 32'(mux_sel), 9);
      reg_rd('h0A, d); check("R4 no flag", 32'(d), 0);

      // R5 go during a running settle window
      start_conv(5, 1'b1);
      repeat (20) @(negedge clk);
      reg_wr('h00, 16'h0001 | 16'(2 << 1), e);
      check("R5 mux_sel kept", 32'(mux_sel), 5);
      wait_idle();
      reg_rd('h08, d); check("R5 data from ch5", 32'(d), 32'(sample_of(4'd5)));
      repeat (20) @(negedge clk);
      check("R5 no pending strobe", 32'(exp_ch_q.size()), 0);
      clear_flag();

      // R10 done while idle ignored
      @(negedge clk); inj_done = 1'b1; inj_data = 16'hDEAD;
      @(negedge clk); inj_done = 1'b0;
      reg_rd('h08, d); check("R10 data unchanged", 32'(d), 32'(sample_of(4'd5)));
      reg_rd('h0A, d); check("R10 flag unchanged", 32'(d), 0);

      // R7 data held across a later read period, then updated
      start_conv(0, 1'b0);
      wait_idle();
      reg_rd('h08, d); check("R7 data ch0", 32'(d), 32'(sample_of(4'd0)));
      repeat (5) @(negedge clk);
      reg_rd('h08, d); check("R7 data held", 32'(d), 32'(sample_of(4'd0)));

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule